// File: doc/BRIEF.md
# Edge-Triggered Input-Capture Channel

This block watches one asynchronous input pin for a chosen transition. It then stores a snapshot of a free-running 16-bit timer count in a capture register and sets a sticky flag for software. The bus clock has two phases. Here they are modelled as one fast system clock and two single-cycle strobes: `ph_fall_en` marks the cycle that ends a bus cycle (the falling edge of the second phase), and `ph_high_en` marks the cycle in which that phase is high and data moves.

Edges are recognised on every system clock, whatever the phase. A recognised edge sets the flag at the next phase-falling strobe. The count is copied at the following phase-high strobe. The timing does not depend on any timer prescale, because the count is simply an input, and it is the same for both polarities. Software reads the 16-bit register as two bytes, high byte first. If a copy falls due in the cycle of a high-byte read, the copy waits until the matching low-byte read has finished, so the two bytes software sees always belong to one snapshot.

Top module: `icap_unit`

## Requirements
- R1: `edge_sel` picks the transition that triggers a capture: 00 none, 01 low-to-high only, 10 high-to-low only, 11 either.
- R2: If the pin changes before clock edge t, the flag rises at the first clock edge n with n >= t+2 at which `ph_fall_en` is high. This holds for every position of t relative to the strobes and for both polarities.
- R3: The capture register loads the `count_in` value present at the first `ph_high_en` edge after the flag-setting edge, unless R5 defers the load.
- R4: `rd_data` is combinational. It shows bits 15:8 of the capture register while `rd_hi` is high (`rd_hi` wins if both strobes are high), bits 7:0 while only `rd_lo` is high, and zero otherwise.
- R5: A high-byte read is `rd_hi` at a `ph_high_en` edge. It locks the register until a later `ph_high_en` edge with `rd_lo`. A copy that falls due at the high-read edge or while the register is locked is deferred to the first `ph_high_en` edge after the unlocking edge that is not itself a high-byte read.
- R6: Between a high-byte read and its low-byte read, the capture register does not change.
- R7: The flag stays set until `flag_clr` is high at a clock edge without a new flag-setting event, and is then low after that edge.
- R8: If `flag_clr` and a flag-setting event occur at the same edge, the flag stays set.
- R9: If a second event arrives while a copy is deferred, the deferred copy is completed first, at the first allowed phase-high edge. A second copy follows at the next phase-high edge, so the register ends with the later value.
- R10: After reset, the flag is low and the capture register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ph_fall_en | input | 1 | Strobe for the phase-falling cycle |
| ph_high_en | input | 1 | Strobe for the phase-high cycle |
| cap_pin | input | 1 | Asynchronous input watched for edges |
| edge_sel | input | 2 | Edge mode (see R1) |
| count_in | input | 16 | Timer count to snapshot |
| rd_hi | input | 1 | High-byte read strobe |
| rd_lo | input | 1 | Low-byte read strobe |
| rd_data | output | 8 | Byte read from the capture register |
| cap_flag | output | 1 | Sticky capture flag |
| flag_clr | input | 1 | Clears the flag (write-one) |

## Verification
A lost or stale edge latch shows up at `cap_flag` within a single bus cycle, either as a flag that rises one phase-falling strobe late or as one that never rises. A wrong pending count or a stuck lock appears in the next byte read as a stale snapshot or a torn pair of bytes. The bench therefore pins each flag rise and each register load to its exact edge, and it reads the register around every deferred copy.

// File: rtl/icap_pkg.sv
`timescale 1ns/1ps
package icap_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/icap_edge_det.sv
`timescale 1ns/1ps
// Pin synchroniser, edge recognition on every system clock, and a latch
// that holds a recognised edge until the next phase-falling strobe.
module icap_edge_det
  import icap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  edge_mode_e mode_i,
  input  logic       fall_en_i,
  output logic       event_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;
  logic                   seen_q, seen_d;
  logic                   lvl, rise, fall, hit;

  always_comb begin
    sync_d[0] = pin_i;
    for (int i = 1; i < SYNC_STAGES; i++) begin
      sync_d[i] = sync_q[i-1];
    end
  end

  assign lvl    = sync_q[LAST];
  assign prev_d = lvl;
  assign rise   = lvl & ~prev_q;
  assign fall   = ~lvl & prev_q;

  always_comb begin
    unique case (mode_i)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_ANY:  hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  // The latch empties on every phase-falling strobe; an edge seen in that
  // very cycle still counts for it.
  assign seen_d  = fall_en_i ? 1'b0 : (seen_q | hit);
  assign event_o = fall_en_i & (seen_q | hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
      seen_q <= seen_d;
    end
  end
endmodule

// File: rtl/icap_seq.sv
`timescale 1ns/1ps
// Flag, pending-copy counter and read lock that defers copies during a
// two-byte read.
module icap_seq #(
  parameter int PEND_MAX = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic event_i,
  input  logic high_en_i,
  input  logic rd_hi_i,
  input  logic rd_lo_i,
  input  logic flag_clr_i,
  output logic flag_o,
  output logic lock_o,
  output logic xfer_o
);
  localparam int PW = $clog2(PEND_MAX + 1);
  localparam logic [PW-1:0] PEND_TOP = PW'(PEND_MAX);

  logic [PW-1:0] pend_q, pend_d;
  logic          flag_q, flag_d;
  logic          lock_q, lock_d;
  logic          hi_read, lo_read, blocked, xfer;

  assign hi_read = high_en_i & rd_hi_i;
  assign lo_read = high_en_i & rd_lo_i & ~rd_hi_i;
  assign blocked = lock_q | hi_read;
  assign xfer    = high_en_i & (pend_q != '0) & ~blocked;

  always_comb begin
    pend_d = pend_q;
    unique case ({event_i, xfer})
      2'b10:   pend_d = (pend_q == PEND_TOP) ? pend_q : pend_q + 1'b1;
      2'b01:   pend_d = pend_q - 1'b1;
      default: pend_d = pend_q;
    endcase
  end

  always_comb begin
    if (event_i)         flag_d = 1'b1;
    else if (flag_clr_i) flag_d = 1'b0;
    else                 flag_d = flag_q;
  end

  always_comb begin
    if (hi_read)      lock_d = 1'b1;
    else if (lo_read) lock_d = 1'b0;
    else              lock_d = lock_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      flag_q <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      flag_q <= flag_d;
      lock_q <= lock_d;
    end
  end

  assign flag_o = flag_q;
  assign lock_o = lock_q;
  assign xfer_o = xfer;
endmodule

// File: rtl/icap_capreg.sv
`timescale 1ns/1ps
// Capture register and byte-read multiplexer (CW must equal 2*BW).
module icap_capreg #(
  parameter int CW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          rd_hi_i,
  input  logic          rd_lo_i,
  output logic [CW-1:0] cap_o,
  output logic [BW-1:0] rd_data_o
);
  localparam int HI_LSB = CW - BW;

  logic [CW-1:0] cap_q, cap_d;

  assign cap_d = load_i ? cnt_i : cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else        cap_q <= cap_d;
  end

  always_comb begin
    if (rd_hi_i)      rd_data_o = cap_q[HI_LSB +: BW];
    else if (rd_lo_i) rd_data_o = cap_q[BW-1:0];
    else              rd_data_o = '0;
  end

  assign cap_o = cap_q;
endmodule

// File: rtl/icap_unit.sv
`timescale 1ns/1ps
module icap_unit
  import icap_pkg::*;
#(
  parameter int CW          = 16,
  parameter int BW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PEND_MAX    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ph_fall_en,
  input  logic          ph_high_en,
  input  logic          cap_pin,
  input  logic [1:0]    edge_sel,
  input  logic [CW-1:0] count_in,
  input  logic          rd_hi,
  input  logic          rd_lo,
  output logic [BW-1:0] rd_data,
  output logic          cap_flag,
  input  logic          flag_clr
);
  logic          evt;
  logic          xfer;
  logic          lock_q;
  logic [CW-1:0] cap_q;

  icap_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (cap_pin),
    .mode_i    (edge_mode_e'(edge_sel)),
    .fall_en_i (ph_fall_en),
    .event_o   (evt)
  );

  icap_seq #(.PEND_MAX(PEND_MAX)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .event_i    (evt),
    .high_en_i  (ph_high_en),
    .rd_hi_i    (rd_hi),
    .rd_lo_i    (rd_lo),
    .flag_clr_i (flag_clr),
    .flag_o     (cap_flag),
    .lock_o     (lock_q),
    .xfer_o     (xfer)
  );

  icap_capreg #(.CW(CW), .BW(BW)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (xfer),
    .cnt_i     (count_in),
    .rd_hi_i   (rd_hi),
    .rd_lo_i   (rd_lo),
    .cap_o     (cap_q),
    .rd_data_o (rd_data)
  );
endmodule

// File: rtl/icap_unit_chk.sv
`timescale 1ns/1ps
module icap_unit_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ph_fall_en,
  input logic          ph_high_en,
  input logic          rd_hi,
  input logic          flag_clr,
  input logic          cap_flag,
  input logic          lock_q,
  input logic [CW-1:0] cap_q
);
  // R2
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_flag) |-> $past(ph_fall_en));

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag && !flag_clr) |=> cap_flag);

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !ph_fall_en) |=> !cap_flag);

  // R3
  load_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_q) |-> $past(ph_high_en && !rd_hi));

  // R6
  no_tear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock_q) |-> $stable(cap_q));
endmodule

bind icap_unit icap_unit_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ph_fall_en (ph_fall_en),
  .ph_high_en (ph_high_en),
  .rd_hi      (rd_hi),
  .flag_clr   (flag_clr),
  .cap_flag   (cap_flag),
  .lock_q     (lock_q),
  .cap_q      (cap_q)
);

// File: tb/tb_icap_unit.sv
`timescale 1ns/1ps
module tb_icap_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ph_fall_en, ph_high_en;
  logic        cap_pin;
  logic [1:0]  edge_sel;
  logic [15:0] count_in;
  logic        rd_hi, rd_lo, flag_clr;
  logic [7:0]  rd_data;
  logic        cap_flag;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [15:0] last_cap;

  always #2 clk = ~clk;

  icap_unit dut (
    .clk(clk), .rst_n(rst_n), .ph_fall_en(ph_fall_en), .ph_high_en(ph_high_en),
    .cap_pin(cap_pin), .edge_sel(edge_sel), .count_in(count_in),
    .rd_hi(rd_hi), .rd_lo(rd_lo), .rd_data(rd_data),
    .cap_flag(cap_flag), .flag_clr(flag_clr)
  );

  function automatic logic [15:0] cnt_at(int n);
    return 16'(n * 37 + 5);
  endfunction

  // R2: first phase-falling edge (multiple of 4) at or after t+2
  function automatic int fall_after(int t);
    return ((t + 5) / 4) * 4;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // Phase strobes and count for the coming edge cyc+1
  always @(negedge clk) begin
    ph_fall_en = ((cyc + 1) % 4 == 0);
    ph_high_en = ((cyc + 1) % 4 == 2);
    count_in   = cnt_at(cyc + 1);
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_until(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic peek(output logic [15:0] v);
    rd_hi = 1'b1;
    #0.5 v[15:8] = rd_data;
    rd_hi = 1'b0;
    rd_lo = 1'b1;
    #0.5 v[7:0] = rd_data;
    rd_lo = 1'b0;
  endtask

  task automatic toggle(output int t);
    cap_pin = ~cap_pin;
    t = cyc + 1;
  endtask

  task automatic clear_at(int n);
    wait_until(n - 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R7 flag cleared", {15'd0, cap_flag}, 16'd0);
  endtask

  task automatic align(int ph);
    @(negedge clk);
    while ((cyc + 1) % 4 != ph) @(negedge clk);
  endtask

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    int t, f, h, tb2;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cap_pin = 1'b0; edge_sel = 2'b00;
    rd_hi = 1'b0; rd_lo = 1'b0; flag_clr = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 flag after reset", {15'd0, cap_flag}, 16'd0);
    peek(v);
    chk("R10 register after reset", v, 16'd0);
    last_cap = 16'd0;

    // R2/R3: every phase position, both polarities
    edge_sel = 2'b11;
    for (int off = 0; off < 8; off++) begin
      align(off % 4);
      toggle(t);
      f = fall_after(t); h = f + 2;
      wait_until(f - 1);
      chk("R2 flag before fall edge", {15'd0, cap_flag}, 16'd0);
      wait_until(f);
      chk("R2 flag at fall edge", {15'd0, cap_flag}, 16'd1);
      wait_until(h - 1);
      peek(v);
      chk("R3 register before load", v, last_cap);
      wait_until(h);
      peek(v);
      chk("R3 register after load", v, cnt_at(h));
      last_cap = cnt_at(h);
      clear_at(h + 3);
    end

    // R1: edge_sel 00 ignores edges
    edge_sel = 2'b00;
    toggle(t);
    wait_until(t + 12);
    chk("R1 disabled flag", {15'd0, cap_flag}, 16'd0);
    peek(v);
    chk("R1 disabled register", v, last_cap);

    // R1: random modes and positions
    for (int i = 0; i < 24; i++) begin
      logic [1:0] sel;
      logic match;
      sel = 2'($urandom % 4);
      @(negedge clk);
      edge_sel = sel;
      repeat ($urandom % 4) @(negedge clk);
      toggle(t);
      match = (sel == 2'b11) || (sel == 2'b01 && cap_pin) || (sel == 2'b10 && !cap_pin);
      f = fall_after(t); h = f + 2;
      wait_until(f);
      chk("R1 flag per edge mode", {15'd0, cap_flag}, {15'd0, match});
      wait_until(h);
      peek(v);
      chk("R1 register per edge mode", v, match ? cnt_at(h) : last_cap);
      if (match) begin
        last_cap = cnt_at(h);
        clear_at(h + 3);
      end else begin
        wait_until(h + 3);
      end
    end

    // R4: both strobes, high byte wins
    @(negedge clk);
    rd_hi = 1'b1; rd_lo = 1'b1;
    #0.5 chk("R4 high strobe wins", {8'd0, rd_data}, {8'd0, last_cap[15:8]});
    rd_hi = 1'b0; rd_lo = 1'b0;
    #0.5 chk("R4 idle data zero", {8'd0, rd_data}, 16'd0);

    // R5/R6: copy due in the high-read cycle is deferred
    edge_sel = 2'b11;
    align(0);
    toggle(t);
    f = fall_after(t); h = f + 2;
    wait_until(h - 1);
    rd_hi = 1'b1;
    #0.5 b = rd_data;
    @(negedge clk);
    rd_hi = 1'b0;
    chk("R6 high byte read", {8'd0, b}, {8'd0, last_cap[15:8]});
    wait_until(h + 3);
    rd_lo = 1'b1;
    #0.5 b = rd_data;
    @(negedge clk);
    rd_lo = 1'b0;
    chk("R6 low byte not torn", {8'd0, b}, {8'd0, last_cap[7:0]});
    peek(v);
    chk("R5 copy still deferred", v, last_cap);
    wait_until(h + 7);
    peek(v);
    chk("R5 copy not before allowed edge", v, last_cap);
    wait_until(h + 8);
    peek(v);
    chk("R5 deferred copy done", v, cnt_at(h + 8));
    last_cap = cnt_at(h + 8);
    clear_at(h + 11);

    // R9: second edge while a copy is deferred
    align(0);
    toggle(t);
    f = fall_after(t); h = f + 2;
    wait_until(t + 3);
    toggle(tb2);
    wait_until(h - 1);
    rd_hi = 1'b1;
    @(negedge clk);
    rd_hi = 1'b0;
    wait_until(h + 3);
    rd_lo = 1'b1;
    @(negedge clk);
    rd_lo = 1'b0;
    wait_until(h + 8);
    peek(v);
    chk("R9 first deferred copy", v, cnt_at(h + 8));
    wait_until(h + 12);
    peek(v);
    chk("R9 later edge wins", v, cnt_at(h + 12));
    last_cap = cnt_at(h + 12);

    // R8: clear coincides with a new set (flag still high from above)
    align(0);
    toggle(t);
    f = fall_after(t); h = f + 2;
    wait_until(f - 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R8 set beats clear", {15'd0, cap_flag}, 16'd1);
    wait_until(h);
    peek(v);
    chk("R3 register after R8 event", v, cnt_at(h));
    clear_at(h + 3);

    summary();
    $finish;
  end
endmodule